// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column address of one burst on a synchronous DRAM data port. A command decoder pulses a start strobe together with the start column, a read/write indication and the burst mode fields. From the next cycle the block presents the first column of the burst. On each cycle with the advance input high it steps to the next column, using sequential or interleaved beat order.

The block raises a last-beat flag on the final beat of a fixed-length burst. It pulses a done flag for one cycle when the burst ends, either on its final beat or through a burst stop command. A new start strobe on any cycle replaces the running burst at once.

Full-page bursts walk the whole row, wrapping from the top column back to zero, until they are stopped or replaced. Write bursts can be forced to a single beat. Reserved mode codes are run as single-beat bursts and raise an error flag.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, active, done, lastBeat and modeErr are 0 and colAddr is 0. colAddr is 0 on every cycle in which active is 0.
- R2: In the cycle after startStb is sampled high, active is 1 and colAddr equals startCol. The mode inputs (lenCode, burstType, isWrite, singleWrite) are sampled only with startStb, and changes to them during a burst have no effect.
- R3: lenCode 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. lastBeat is 1 exactly on the final beat. An advance on the final beat makes active 0 and done 1 in the next cycle, and done is 1 for one cycle only.
- R4: With burstType 0 (sequential), beat i of a burst of L beats keeps the bits of startCol above bit log2(L)-1. Its low log2(L) bits are (startCol + i) mod L.
- R5: With burstType 1 (interleaved), beat i keeps the upper bits of startCol. Its low log2(L) bits are the low bits of startCol XOR i.
- R6: lenCode 111 with burstType 0 is full page: beat i is (startCol + i) mod 512. lastBeat stays 0, and the burst runs until it is stopped or replaced.
- R7: While advance is 0 (and no start or stop), a running burst holds its column and stays active.
- R8: stopCmd while active (and startStb low) makes active 0 and done 1 in the next cycle. stopCmd while idle has no effect.
- R9: startStb while a burst runs restarts it from the new startCol with the new modes, and done stays 0. startStb has priority over stopCmd and advance in the same cycle.
- R10: When isWrite and singleWrite are both 1 at the start, the burst has one beat whatever lenCode is. With isWrite 0, singleWrite has no effect.
- R11: lenCode 100, 101 and 110, and lenCode 111 with burstType 1, run a one-beat burst. modeErr is 1 from the cycle after that start until the cycle after the next start with a legal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Read or write command: begin a new burst |
| startCol | input | 9 | Start column of the burst |
| isWrite | input | 1 | 1 when the command is a write |
| lenCode | input | 3 | Burst length code |
| burstType | input | 1 | 0 sequential, 1 interleaved |
| singleWrite | input | 1 | Force write bursts to one beat |
| stopCmd | input | 1 | Burst stop command |
| advance | input | 1 | Step to the next beat |
| colAddr | output | 9 | Column of the current beat, 0 when idle |
| active | output | 1 | A burst is running |
| lastBeat | output | 1 | Current beat is the final one |
| done | output | 1 | One-cycle pulse when a burst ends |
| modeErr | output | 1 | Last start used a reserved mode |

## Verification
The bench targets start columns whose low bits are not zero. A design that carried into the upper bits or ignored the start offset would leave the aligned block at the wrap point. Interleaved bursts from odd starts would show the same fault, or an adder in place of the XOR. A full-page burst crossing column 511 would expose a missing wrap or a false last beat. Restarts mid-burst, start and stop in the same cycle, stop while idle and stalled advance show up as a spurious done pulse, a lost restart or a skipped beat. Reserved codes and forced single writes catch a design that runs the wrong length or leaves the error flag stale.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int LEN_CODE_W = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       step;
    logic       interleave;
    logic       fullPage;
    logic [1:0] lenLog;
  } colCtrl_t;

  typedef struct packed {
    logic       fullPage;
    logic [1:0] lenLog;
    logic       reserved;
  } modeDec_t;

  function automatic modeDec_t decodeMode(input logic [LEN_CODE_W-1:0] code,
                                          input logic interleave,
                                          input logic forceSingle);
    modeDec_t d;
    d = '0;
    case (code)
      3'b000, 3'b001, 3'b010, 3'b011: d.lenLog = code[1:0];
      3'b111: begin
        if (interleave) d.reserved = 1'b1;
        else            d.fullPage = 1'b1;
      end
      default: d.reserved = 1'b1;
    endcase
    if (forceSingle) begin
      d.fullPage = 1'b0;
      d.lenLog   = 2'd0;
    end
    if (d.reserved) begin
      d.fullPage = 1'b0;
      d.lenLog   = 2'd0;
    end
    return d;
  endfunction

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startStb,
  input  logic                  isWrite,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  burstType,
  input  logic                  singleWrite,
  input  logic                  stopCmd,
  input  logic                  advance,
  output colCtrl_t              ctrl,
  output logic                  active,
  output logic                  lastBeat,
  output logic                  done,
  output logic                  modeErr
);

  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic             activeQ, fullQ, interQ, errQ, doneQ;
  logic [1:0]       logQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] lenLast;
  logic             finalBeat;
  modeDec_t         dec;

  always_comb begin
    dec       = decodeMode(lenCode, burstType, isWrite & singleWrite);
    lenLast   = (ONE << logQ) - ONE;
    finalBeat = activeQ & ~fullQ & (beatQ == lenLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      fullQ   <= 1'b0;
      interQ  <= 1'b0;
      errQ    <= 1'b0;
      doneQ   <= 1'b0;
      logQ    <= 2'd0;
      beatQ   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (startStb) begin
        activeQ <= 1'b1;
        beatQ   <= '0;
        fullQ   <= dec.fullPage;
        logQ    <= dec.lenLog;
        interQ  <= burstType;
        errQ    <= dec.reserved;
      end else if (activeQ && stopCmd) begin
        activeQ <= 1'b0;
        doneQ   <= 1'b1;
      end else if (activeQ && advance) begin
        if (finalBeat) begin
          activeQ <= 1'b0;
          doneQ   <= 1'b1;
        end else begin
          beatQ <= beatQ + ONE;
        end
      end
    end
  end

  always_comb begin
    ctrl.load       = startStb;
    ctrl.step       = ~startStb & activeQ & ~stopCmd & advance & ~finalBeat;
    ctrl.interleave = interQ;
    ctrl.fullPage   = fullQ;
    ctrl.lenLog     = logQ;
    active          = activeQ;
    lastBeat        = finalBeat;
    done            = doneQ;
    modeErr         = errQ;
  end

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  colCtrl_t         ctrl,
  input  logic [COL_W-1:0] startCol,
  input  logic             active,
  output logic [COL_W-1:0] colAddr
);

  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic [COL_W-1:0] startQ, offsQ;
  logic [COL_W-1:0] mask, seqLow, intLow, lowSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      offsQ  <= '0;
    end else if (ctrl.load) begin
      startQ <= startCol;
      offsQ  <= '0;
    end else if (ctrl.step) begin
      offsQ <= offsQ + ONE;
    end
  end

  always_comb begin
    mask   = ctrl.fullPage ? '1 : ((ONE << ctrl.lenLog) - ONE);
    seqLow = startQ + offsQ;
    intLow = startQ ^ offsQ;
    lowSel = ctrl.interleave ? intLow : seqLow;
  end

  // per-bit merge: masked bits follow the beat order, the rest keep the start
  for (genvar i = 0; i < COL_W; i++) begin : g_merge
    assign colAddr[i] = active & (mask[i] ? lowSel[i] : startQ[i]);
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startStb,
  input  logic [COL_W-1:0]      startCol,
  input  logic                  isWrite,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  burstType,
  input  logic                  singleWrite,
  input  logic                  stopCmd,
  input  logic                  advance,
  output logic [COL_W-1:0]      colAddr,
  output logic                  active,
  output logic                  lastBeat,
  output logic                  done,
  output logic                  modeErr
);

  colCtrl_t ctrl;

  burst_col_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .isWrite(isWrite),
    .lenCode(lenCode), .burstType(burstType), .singleWrite(singleWrite),
    .stopCmd(stopCmd), .advance(advance), .ctrl(ctrl), .active(active),
    .lastBeat(lastBeat), .done(done), .modeErr(modeErr)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startCol(startCol),
    .active(active), .colAddr(colAddr)
  );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic             stopCmd,
  input logic             advance,
  input logic [COL_W-1:0] colAddr,
  input logic             active,
  input logic             lastBeat,
  input logic             done
);

  a_r1_idle_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> colAddr == '0);

  a_r2_start_activates: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> active);

  a_r3_final_beat_ends: assert property (@(posedge clk) disable iff (!rstN)
    (active && lastBeat && advance && !startStb && !stopCmd) |=> (done && !active));

  a_r3_done_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_last_needs_active: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> active);

  a_r7_hold_without_advance: assert property (@(posedge clk) disable iff (!rstN)
    (active && !advance && !startStb && !stopCmd) |=> (active && $stable(colAddr)));

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (active && stopCmd && !startStb) |=> (done && !active));

  a_r9_restart_no_done: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> !done);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .stopCmd(stopCmd),
  .advance(advance), .colAddr(colAddr), .active(active),
  .lastBeat(lastBeat), .done(done)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic [8:0] startCol = '0;
  logic       isWrite = 1'b0;
  logic [2:0] lenCode = '0;
  logic       burstType = 1'b0;
  logic       singleWrite = 1'b0;
  logic       stopCmd = 1'b0;
  logic       advance = 1'b0;
  logic [8:0] colAddr;
  logic       active, lastBeat, done, modeErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  int  mStart = 0, mBeat = 0, mLen = 1;   // mLen 0 = full page
  bit  mInter = 0, mActive = 0, mDone = 0, mErr = 0;

  always #5 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .isWrite(isWrite), .lenCode(lenCode), .burstType(burstType),
    .singleWrite(singleWrite), .stopCmd(stopCmd), .advance(advance),
    .colAddr(colAddr), .active(active), .lastBeat(lastBeat), .done(done),
    .modeErr(modeErr)
  );

  function automatic int expAddr();
    int mask, low;
    if (!mActive) return 0;
    mask = (mLen == 0) ? 511 : mLen - 1;
    low  = mInter ? ((mStart ^ mBeat) & mask) : ((mStart + mBeat) & mask);
    return (mStart & ~mask & 511) | low;
  endfunction

  function automatic bit expLast();
    return mActive && mLen != 0 && mBeat == mLen - 1;
  endfunction

  task automatic modelEdge();
    if (!rstN) begin
      mActive = 0; mDone = 0; mErr = 0; mBeat = 0; mStart = 0; mLen = 1;
    end else if (startStb) begin
      mErr = 0;
      if (lenCode <= 3)                   mLen = 1 << lenCode;
      else if (lenCode == 7 && !burstType) mLen = 0;
      else begin mLen = 1; mErr = 1; end
      if (isWrite && singleWrite) mLen = 1;
      mActive = 1; mBeat = 0; mStart = startCol; mInter = burstType; mDone = 0;
    end else if (stopCmd && mActive) begin
      mActive = 0; mDone = 1;
    end else if (advance && mActive) begin
      if (expLast()) begin mActive = 0; mDone = 1; end
      else begin mBeat = (mBeat + 1) % 512; mDone = 0; end
    end else begin
      mDone = 0;
    end
  endtask

  task automatic compare();
    int ea;
    ea = expAddr();
    checks++;
    if (colAddr !== 9'(ea) || active !== mActive || lastBeat !== expLast() ||
        done !== mDone || modeErr !== mErr) begin
      errors++;
      $display("FAIL %s: addr=%h act=%b last=%b done=%b err=%b expected addr=%h act=%b last=%b done=%b err=%b",
               curReq, colAddr, active, lastBeat, done, modeErr,
               ea[8:0], mActive, expLast(), mDone, mErr);
    end
  endtask

  // one clock: model follows the edge, outputs compared 2 ns later
  task automatic tick();
    @(posedge clk);
    modelEdge();
    #2;
    compare();
  endtask

  task automatic idleIn();
    startStb = 0; stopCmd = 0; advance = 0;
  endtask

  task automatic begin_(input int col, input int code, input bit typ, input bit wr);
    startStb = 1; startCol = 9'(col); lenCode = 3'(code); burstType = typ;
    isWrite = wr; stopCmd = 0; advance = 0;
    tick();
    startStb = 0;
  endtask

  task automatic run(input int n);
    advance = 1;
    for (int k = 0; k < n; k++) tick();
    advance = 0;
  endtask

  task automatic expectAddr(input string req, input int exp);
    checks++;
    if (colAddr !== 9'(exp)) begin
      errors++;
      $display("FAIL %s: addr=%h expected %h", req, colAddr, 9'(exp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset
    curReq = "R1";
    tick(); tick();
    rstN = 1;
    tick();

    // R3 and R4: sequential lengths from an unaligned start
    curReq = "R4";
    for (int c = 0; c < 4; c++) begin
      begin_(9'h0D5, c, 0, 0);
      run((1 << c) + 1);
      tick();
    end
    curReq = "R3";
    begin_(9'h123, 3, 0, 0);
    run(7);
    curReq = "R3"; // final beat then done pulse
    run(1);
    tick();

    // R5 interleaved
    curReq = "R5";
    for (int c = 1; c < 4; c++) begin
      begin_(9'h1A6, c, 1, 0);
      run((1 << c) + 1);
    end
    begin_(9'h0B5, 3, 1, 0);
    run(1);
    expectAddr("R5", 9'h0B4);

    // R7 stalled advance
    curReq = "R7";
    begin_(9'h046, 2, 0, 0);
    run(1); tick(); tick(); run(1); tick(); run(3);

    // R6 full page wrap, then R8 stop
    curReq = "R6";
    begin_(9'h1FD, 7, 0, 0);
    run(2);
    expectAddr("R6", 9'h1FF);
    run(1);
    expectAddr("R6", 9'h000);
    run(600);
    curReq = "R8";
    stopCmd = 1; tick(); stopCmd = 0;
    tick();
    stopCmd = 1; tick(); tick(); stopCmd = 0; // stop while idle
    tick();

    // R9 interrupt mid-burst, start beats stop and advance
    curReq = "R9";
    begin_(9'h0F0, 3, 0, 0);
    run(3);
    begin_(9'h077, 2, 1, 0);
    run(1);
    startStb = 1; stopCmd = 1; advance = 1; startCol = 9'h155;
    lenCode = 3'd1; burstType = 0; isWrite = 0;
    tick();
    idleIn();
    run(3);

    // R2 mode inputs ignored during burst
    curReq = "R2";
    begin_(9'h0C9, 2, 0, 0);
    lenCode = 3'd7; burstType = 1; isWrite = 1; singleWrite = 1;
    startCol = 9'h1FF;
    run(5);
    singleWrite = 0;

    // R10 single write
    curReq = "R10";
    singleWrite = 1;
    begin_(9'h033, 3, 0, 1);
    run(2);
    begin_(9'h033, 3, 0, 0);
    run(9);
    begin_(9'h033, 7, 0, 1);
    run(2);
    singleWrite = 0;
    begin_(9'h031, 1, 0, 1);
    run(3);

    // R11 reserved codes
    curReq = "R11";
    for (int c = 4; c < 7; c++) begin
      begin_(9'h0AB, c, 0, 0);
      run(2);
    end
    begin_(9'h0AB, 7, 1, 0);
    run(2); tick();
    begin_(9'h0AB, 0, 0, 0);
    run(2);

    curReq = "R1";
    rstN = 0; tick(); rstN = 1; tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule